// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block is the digital core of a frequency synthesizer's divider chain. On the oscillator side, a prescaler divides by either P or P+1. A swallow count A and a main count B then sequence the prescaler modulus, so that one main output period lasts exactly P·B + A oscillator clocks. The base modulus P is selectable as 64 or 128. Because A steps the total ratio by one clock at a time, the output frequency can be set in fine steps even though the prescaler only has a coarse modulus.

On the reference side, a separate counter divides the reference clock by R. The two divided pulses are what a phase comparator would compare. The divide values come from a settings latch outside the block. A new value is picked up only when the counter it belongs to reaches terminal count, so changing a setting never truncates or stretches the cycle in progress.

Top module: `psw_divider`

## Requirements
- R1: One main period lasts exactly P·B + A cycles of `clk_vco`. At the end of each period, `fp` is high for exactly one `clk_vco` cycle.
- R2: `p_sel` = 0 selects the base modulus P = 64 (64/65 pair). `p_sel` = 1 selects P = 128 (128/129 pair).
- R3: `mod_hi` (1 = prescaler at P+1, 0 = at P) is high for the first A·(P+1) `clk_vco` cycles of each main period and low for the rest. It rises only in the cycle in which `fp` is high.
- R4: When A = 0, `mod_hi` stays low for the whole main period. In the cycle in which `fp` is high, `mod_hi` shows whether the new period's A is non-zero.
- R5: When A = B, `mod_hi` stays high for the whole main period, and the period is B·(P+1).
- R6: `fr` is high for one `clk_ref` cycle once every R cycles of `clk_ref`.
- R7: Changes to `a_val`, `b_val` or `p_sel` during a main period do not alter that period. They apply from the next terminal count.
- R8: A change to `r_val` during a reference period does not alter that period. It applies from the next `fr` terminal count.
- R9: A value of `b_val` below 3 is treated as 3. A value of `r_val` below 3 is treated as 3.
- R10: A value of `a_val` greater than the effective B is treated as equal to B.
- R11: While `rst_n` is low at a clock edge, `fp` and `fr` are low and `mod_hi` shows whether A is non-zero. The first `fp` follows P·B + A `clk_vco` cycles after reset is released, and the first `fr` follows R `clk_ref` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator-side clock being divided |
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled in both clock domains |
| a_val | input | 7 | Swallow count A |
| b_val | input | 11 | Main count B |
| r_val | input | 14 | Reference divide ratio R |
| p_sel | input | 1 | Base modulus select: 0 gives 64, 1 gives 128 |
| fp | output | 1 | Divided main pulse, one `clk_vco` cycle wide |
| mod_hi | output | 1 | Modulus control: 1 means P+1, 0 means P |
| fr | output | 1 | Divided reference pulse, one `clk_ref` cycle wide |

## Verification
On every clock, the assertions check three things:
- the length of each main and reference period, against the settings captured at the previous terminal count (with the clamping applied);
- the single-cycle width of both pulses;
- that the modulus control rises only at a period boundary and starts each period at the right level.

Other properties are exercised only by the bench scenarios, through a behavioural model compared on every cycle. These are how many cycles the modulus control stays high within a period, the A = 0 and A = B extremes, and the rule that a setting changed part-way through a period waits for the next boundary.

// File: rtl/psw_pkg.sv
// Shared constants, the modulus-select encoding and a length helper for the
// pulse-swallow divider. Assumes nothing beyond IEEE 1800-2017.
package psw_pkg;

    // Smallest legal B and R; lower requests are raised to this value.
    localparam int unsigned PSW_MIN_DIV = 3;

    // Base modulus selection encoding on the p_sel pin.
    typedef enum logic {
        PSEL_LOW  = 1'b0,   // base modulus is the small one (64)
        PSEL_HIGH = 1'b1    // base modulus is the large one (128)
    } psel_e;

    // Expected main period in input clocks for raw settings, clamps applied.
    function automatic int psw_main_len(int a, int b, bit big, int p_lo, int p_hi);
        int b_e;
        int a_e;
        b_e = (b < int'(PSW_MIN_DIV)) ? int'(PSW_MIN_DIV) : b;
        a_e = (a > b_e) ? b_e : a;
        return (big ? p_hi : p_lo) * b_e + a_e;
    endfunction

    // Expected reference period in reference clocks, clamp applied.
    function automatic int psw_ref_len(int r);
        return (r < int'(PSW_MIN_DIV)) ? int'(PSW_MIN_DIV) : r;
    endfunction

endpackage

// File: rtl/psw_cfg_clamp.sv
// Settings clamp: raises B to the minimum legal ratio and limits A to the
// effective B, so the swallow phase never outlasts the main count.
// Assumes B_W >= A_W (the swallow count is never wider than the main count).
module psw_cfg_clamp #(
    parameter int unsigned A_W     = 7,
    parameter int unsigned B_W     = 11,
    parameter int unsigned MIN_DIV = 3
) (
    input  logic [A_W-1:0] a_raw,
    input  logic [B_W-1:0] b_raw,
    output logic [A_W-1:0] a_eff,
    output logic [B_W-1:0] b_eff
);

    logic [B_W-1:0] a_wide;

    // Raise B to the smallest legal ratio.
    always_comb begin
        b_eff = (b_raw < B_W'(MIN_DIV)) ? B_W'(MIN_DIV) : b_raw;
    end

    // Widen A to the width of B, choosing the form by the relative widths.
    generate
        if (B_W > A_W) begin : g_extend
            assign a_wide = {{(B_W - A_W){1'b0}}, a_raw};
        end else begin : g_same
            assign a_wide = a_raw[B_W-1:0];
        end
    endgenerate

    // Limit A to the effective B.
    always_comb begin
        if (a_wide > b_eff) begin
            a_eff = b_eff[A_W-1:0];
        end else begin
            a_eff = a_raw;
        end
    end

endmodule

// File: rtl/psw_prescaler.sv
// Dual-modulus prescaler model: counts input clocks and marks the last clock
// of every prescaler cycle with pre_tc. The modulus is the base P, or P+1
// while plus1 is high. Assumes plus1 and big_p change only when pre_tc fires,
// which the swallow controller guarantees.
module psw_prescaler
    import psw_pkg::*;
#(
    parameter int unsigned P_LO = 64,
    parameter int unsigned P_HI = 128,
    parameter int unsigned PC_W = $clog2(P_HI + 2)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  psel_e big_p,
    input  logic  plus1,
    output logic  pre_tc
);

    logic [PC_W-1:0] cnt_q;
    logic [PC_W-1:0] modulus;

    // Current modulus: the base selected by big_p, plus one while swallowing.
    always_comb begin
        modulus = ((big_p == PSEL_HIGH) ? PC_W'(P_HI) : PC_W'(P_LO))
                + {{(PC_W - 1){1'b0}}, plus1};
    end

    // Terminal count of the prescaler cycle.
    assign pre_tc = (cnt_q == (modulus - PC_W'(1)));

    // Count input clocks and restart at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_tc) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PC_W'(1);
        end
    end

endmodule

// File: rtl/psw_swallow_ctrl.sv
// Swallow and main counters. Both count prescaler cycles. The swallow count
// keeps the prescaler at P+1 until it is exhausted; the main count ends the
// period, reloads both counts and the modulus select from the settings, and
// emits a one-clock pulse. Assumes b_eff >= 3 and a_eff <= b_eff, which the
// upstream clamp provides.
module psw_swallow_ctrl
    import psw_pkg::*;
#(
    parameter int unsigned A_W = 7,
    parameter int unsigned B_W = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tc,
    input  logic [A_W-1:0] a_eff,
    input  logic [B_W-1:0] b_eff,
    input  psel_e          big_in,
    output logic           plus1,
    output psel_e          big_p,
    output logic           fp
);

    logic [A_W-1:0] a_left_q;
    logic [B_W-1:0] b_left_q;
    psel_e          big_q;
    logic           fp_q;
    logic           period_end;

    // The last prescaler cycle of the main period is ending.
    assign period_end = pre_tc && (b_left_q == B_W'(1));

    // Count prescaler cycles; reload everything only at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_left_q <= a_eff;
            b_left_q <= b_eff;
            big_q    <= big_in;
            fp_q     <= 1'b0;
        end else if (period_end) begin
            a_left_q <= a_eff;
            b_left_q <= b_eff;
            big_q    <= big_in;
            fp_q     <= 1'b1;
        end else begin
            fp_q <= 1'b0;
            if (pre_tc) begin
                b_left_q <= b_left_q - B_W'(1);
                if (a_left_q != '0) begin
                    a_left_q <= a_left_q - A_W'(1);
                end
            end
        end
    end

    assign plus1 = (a_left_q != '0);
    assign big_p = big_q;
    assign fp    = fp_q;

endmodule

// File: rtl/psw_ref_div.sv
// Reference divider: divides the reference clock by R and emits a pulse one
// reference clock wide on the last clock of each period. A new R is taken
// only at terminal count. Requests below MIN_DIV are raised to MIN_DIV.
module psw_ref_div #(
    parameter int unsigned R_W     = 14,
    parameter int unsigned MIN_DIV = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [R_W-1:0] r_raw,
    output logic           fr
);

    logic [R_W-1:0] r_eff;
    logic [R_W-1:0] r_cur_q;
    logic [R_W-1:0] cnt_q;
    logic           fr_q;

    // Raise R to the smallest legal ratio.
    always_comb begin
        r_eff = (r_raw < R_W'(MIN_DIV)) ? R_W'(MIN_DIV) : r_raw;
    end

    // Count reference clocks; reload the ratio and pulse at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            r_cur_q <= r_eff;
            fr_q    <= 1'b0;
        end else if (cnt_q == (r_cur_q - R_W'(1))) begin
            cnt_q   <= '0;
            r_cur_q <= r_eff;
            fr_q    <= 1'b1;
        end else begin
            cnt_q <= cnt_q + R_W'(1);
            fr_q  <= 1'b0;
        end
    end

    assign fr = fr_q;

endmodule

// File: rtl/psw_divider.sv
// Pulse-swallow dual-modulus divider, top level. The oscillator clock is
// divided by P*B + A through a P/P+1 prescaler sequenced by swallow and main
// counters. The reference clock is divided by R in its own domain. rst_n is
// synchronous and sampled in both clock domains; the settings are assumed
// static relative to each domain's clock, as they come from a settings latch.
module psw_divider
    import psw_pkg::*;
#(
    parameter int unsigned A_W  = 7,
    parameter int unsigned B_W  = 11,
    parameter int unsigned R_W  = 14,
    parameter int unsigned P_LO = 64,
    parameter int unsigned P_HI = 128
) (
    input  logic           clk_vco,
    input  logic           clk_ref,
    input  logic           rst_n,
    input  logic [A_W-1:0] a_val,
    input  logic [B_W-1:0] b_val,
    input  logic [R_W-1:0] r_val,
    input  logic           p_sel,
    output logic           fp,
    output logic           mod_hi,
    output logic           fr
);

    localparam int unsigned PC_W = $clog2(P_HI + 2);

    logic [A_W-1:0] a_eff;
    logic [B_W-1:0] b_eff;
    logic           pre_tc;
    logic           plus1;
    psel_e          big_sel;
    psel_e          big_in;

    assign big_in = psel_e'(p_sel);

    psw_cfg_clamp #(
        .A_W     (A_W),
        .B_W     (B_W),
        .MIN_DIV (PSW_MIN_DIV)
    ) u_clamp (
        .a_raw (a_val),
        .b_raw (b_val),
        .a_eff (a_eff),
        .b_eff (b_eff)
    );

    psw_prescaler #(
        .P_LO (P_LO),
        .P_HI (P_HI),
        .PC_W (PC_W)
    ) u_pre (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .big_p  (big_sel),
        .plus1  (plus1),
        .pre_tc (pre_tc)
    );

    psw_swallow_ctrl #(
        .A_W (A_W),
        .B_W (B_W)
    ) u_swallow (
        .clk    (clk_vco),
        .rst_n  (rst_n),
        .pre_tc (pre_tc),
        .a_eff  (a_eff),
        .b_eff  (b_eff),
        .big_in (big_in),
        .plus1  (plus1),
        .big_p  (big_sel),
        .fp     (fp)
    );

    psw_ref_div #(
        .R_W     (R_W),
        .MIN_DIV (PSW_MIN_DIV)
    ) u_ref (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .r_raw (r_val),
        .fr    (fr)
    );

    assign mod_hi = plus1;

endmodule

// File: rtl/psw_divider_chk.sv
// Checker for psw_divider: measures every main and reference period against
// the settings captured at the previous terminal count, and checks the pulse
// widths and the modulus-control transitions. Bound to the top module below.
module psw_divider_chk
    import psw_pkg::*;
#(
    parameter int unsigned A_W  = 7,
    parameter int unsigned B_W  = 11,
    parameter int unsigned R_W  = 14,
    parameter int unsigned P_LO = 64,
    parameter int unsigned P_HI = 128
) (
    input logic           clk_vco,
    input logic           clk_ref,
    input logic           rst_n,
    input logic [A_W-1:0] a_val,
    input logic [B_W-1:0] b_val,
    input logic [R_W-1:0] r_val,
    input logic           p_sel,
    input logic           fp,
    input logic           mod_hi,
    input logic           fr
);

    int m_len_q, m_exp_q, m_nxt_q;
    int r_len_q, r_exp_q, r_nxt_q;

    // Main-side period counter and the expected length from captured settings.
    always_ff @(posedge clk_vco) begin
        if (!rst_n) begin
            m_len_q <= 0;
            m_exp_q <= psw_main_len(int'(a_val), int'(b_val), p_sel, int'(P_LO), int'(P_HI));
            m_nxt_q <= psw_main_len(int'(a_val), int'(b_val), p_sel, int'(P_LO), int'(P_HI));
        end else begin
            m_nxt_q <= psw_main_len(int'(a_val), int'(b_val), p_sel, int'(P_LO), int'(P_HI));
            if (fp) begin
                m_len_q <= 1;
                m_exp_q <= m_nxt_q;
            end else begin
                m_len_q <= m_len_q + 1;
            end
        end
    end

    // Reference-side period counter and the expected length.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            r_len_q <= 0;
            r_exp_q <= psw_ref_len(int'(r_val));
            r_nxt_q <= psw_ref_len(int'(r_val));
        end else begin
            r_nxt_q <= psw_ref_len(int'(r_val));
            if (fr) begin
                r_len_q <= 1;
                r_exp_q <= r_nxt_q;
            end else begin
                r_len_q <= r_len_q + 1;
            end
        end
    end

    // R1, R7, R9, R10: main period equals the clamped P*B+A of its settings.
    assert_fp_period_R1: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |-> (m_len_q == m_exp_q));

    // R1: the main pulse lasts one clock.
    assert_fp_pulse_R1: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |=> !fp);

    // R3: the modulus control rises only at a period boundary.
    assert_mod_rise_R3: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $rose(mod_hi) |-> fp);

    // R4: at a period start, the modulus control shows whether the new A is non-zero.
    assert_mod_start_R4: assert property (@(posedge clk_vco) disable iff (!rst_n)
        fp |-> (mod_hi == ($past(a_val) != '0)));

    // R6, R8: reference period equals the clamped R of its settings.
    assert_fr_period_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fr |-> (r_len_q == r_exp_q));

    // R6: the reference pulse lasts one clock.
    assert_fr_pulse_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
        fr |=> !fr);

endmodule

bind psw_divider psw_divider_chk #(
    .A_W  (A_W),
    .B_W  (B_W),
    .R_W  (R_W),
    .P_LO (P_LO),
    .P_HI (P_HI)
) u_chk (
    .clk_vco (clk_vco),
    .clk_ref (clk_ref),
    .rst_n   (rst_n),
    .a_val   (a_val),
    .b_val   (b_val),
    .r_val   (r_val),
    .p_sel   (p_sel),
    .fp      (fp),
    .mod_hi  (mod_hi),
    .fr      (fr)
);

// File: tb/psw_divider_test.sv
// Bench for psw_divider: a behavioural reference model compared on every
// clock of both domains, plus scenario checks of period lengths and
// modulus-control occupancy.
module psw_divider_test;

    logic        clk_vco = 1'b0;
    logic        clk_ref = 1'b0;
    logic        rst_n   = 1'b0;
    logic [6:0]  a_val   = 7'd5;
    logic [10:0] b_val   = 11'd8;
    logic [13:0] r_val   = 14'd10;
    logic        p_sel   = 1'b0;
    logic        fp, mod_hi, fr;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string vreq   = "R11";
    string rreq   = "R11";

    psw_divider uut (
        .clk_vco (clk_vco),
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .a_val   (a_val),
        .b_val   (b_val),
        .r_val   (r_val),
        .p_sel   (p_sel),
        .fp      (fp),
        .mod_hi  (mod_hi),
        .fr      (fr)
    );

    always #5 clk_vco = ~clk_vco;
    always #7 clk_ref = ~clk_ref;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model, main side: period lengths from requirement R1 with clamps R9 and R10.
    int vcnt = 0, n_cur = 0, a_cur = 0, p_cur = 0;
    bit e_fp = 1'b0, vlive = 1'b0;

    task automatic load_main();
        int b, a;
        b = (int'(b_val) < 3) ? 3 : int'(b_val);
        a = (int'(a_val) > b) ? b : int'(a_val);
        p_cur = p_sel ? 128 : 64;
        a_cur = a;
        n_cur = p_cur * b + a;
    endtask

    always @(posedge clk_vco) begin
        if (!rst_n) begin
            vcnt = 0; e_fp = 1'b0; load_main(); vlive = 1'b1;
        end else begin
            vcnt++;
            if (vcnt == n_cur) begin
                e_fp = 1'b1; vcnt = 0; load_main();
            end else begin
                e_fp = 1'b0;
            end
        end
    end

    always @(negedge clk_vco) begin
        if (vlive && !done) begin
            check(vreq, "fp", int'(fp), int'(e_fp));
            check(vreq, "mod_hi", int'(mod_hi), int'(vcnt < a_cur * (p_cur + 1)));
        end
    end

    // Behavioural model, reference side (R6, R8, R9).
    int rcnt = 0, r_cur = 0;
    bit e_fr = 1'b0, rlive = 1'b0;

    always @(posedge clk_ref) begin
        if (!rst_n) begin
            rcnt = 0; e_fr = 1'b0; rlive = 1'b1;
            r_cur = (int'(r_val) < 3) ? 3 : int'(r_val);
        end else begin
            rcnt++;
            if (rcnt == r_cur) begin
                e_fr = 1'b1; rcnt = 0;
                r_cur = (int'(r_val) < 3) ? 3 : int'(r_val);
            end else begin
                e_fr = 1'b0;
            end
        end
    end

    always @(negedge clk_ref) begin
        if (rlive && !done) check(rreq, "fr", int'(fr), int'(e_fr));
    end

    // Measure the next full main period: its length and its mod_hi-high cycles.
    task automatic measure(output int gap, output int hi);
        @(negedge clk_vco);
        while (!fp) @(negedge clk_vco);
        gap = 0; hi = 0;
        do begin
            hi += int'(mod_hi);
            @(negedge clk_vco);
            gap++;
        end while (!fp);
    endtask

    task automatic fr_gap(output int gap);
        @(negedge clk_ref);
        while (!fr) @(negedge clk_ref);
        gap = 0;
        do begin
            @(negedge clk_ref);
            gap++;
        end while (!fr);
    endtask

    initial begin
        int gap, hi;
        repeat (4) @(negedge clk_vco);
        // R11: reset state
        check("R11", "fp in reset", int'(fp), 0);
        check("R11", "fr in reset", int'(fr), 0);
        check("R11", "mod_hi in reset", int'(mod_hi), 1);
        rst_n = 1'b1;

        // Reference side: R6, then R9 clamp, then R8 mid-period change.
        rreq = "R6";
        fr_gap(gap);   check("R6", "fr period R=10", gap, 10);
        rreq = "R9"; @(negedge clk_ref); r_val = 14'd2;
        fr_gap(gap);   fr_gap(gap); check("R9", "fr period R=2 clamped", gap, 3);
        rreq = "R8";
        @(negedge clk_ref); while (!fr) @(negedge clk_ref);
        @(negedge clk_ref); r_val = 14'd7;
        gap = 0;
        do begin @(negedge clk_ref); gap++; end while (!fr);
        check("R8", "old R period kept", gap, 2);
        fr_gap(gap);   check("R8", "new R period", gap, 7);

        // R1 and R3: A=5 B=8 P=64 gives 517, with 325 cycles at P+1.
        vreq = "R1";
        measure(gap, hi); check("R1", "period A5 B8 P64", gap, 517);
        check("R3", "mod_hi high cycles", hi, 325);

        // R2: P=128, A=3, B=4 gives 515, with 387 cycles at P+1.
        vreq = "R2"; a_val = 7'd3; b_val = 11'd4; p_sel = 1'b1;
        measure(gap, hi); check("R2", "period A3 B4 P128", gap, 515);
        check("R2", "mod_hi high cycles P128", hi, 387);

        // R4: A=0 keeps the base modulus all period.
        vreq = "R4"; a_val = 7'd0; b_val = 11'd5; p_sel = 1'b0;
        measure(gap, hi); check("R4", "period A0 B5", gap, 320);
        check("R4", "mod_hi never high", hi, 0);

        // R5: A=B keeps P+1 all period.
        vreq = "R5"; a_val = 7'd6; b_val = 11'd6;
        measure(gap, hi); check("R5", "period A=B=6", gap, 390);
        check("R5", "mod_hi always high", hi, 390);

        // R9: B below 3 is treated as 3.
        vreq = "R9"; a_val = 7'd2; b_val = 11'd1;
        measure(gap, hi); check("R9", "period B clamped to 3", gap, 194);

        // R10: A above B is treated as B.
        vreq = "R10"; a_val = 7'd20; b_val = 11'd4;
        measure(gap, hi); check("R10", "period A clamped to B", gap, 260);
        check("R10", "mod_hi high cycles", hi, 260);

        // R7: a mid-period change waits for the terminal count.
        vreq = "R7";
        repeat (100) @(negedge clk_vco);
        a_val = 7'd0; b_val = 11'd3; p_sel = 1'b1;
        gap = 0;
        do begin @(negedge clk_vco); gap++; end while (!fp);
        check("R7", "old period finishes", gap, 160);
        measure(gap, hi); check("R7", "new period A0 B3 P128", gap, 384);

        repeat (20) @(negedge clk_vco);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule